// File: doc/BRIEF.md
# Sorted Divergent-Path Tracker for One SIMT Warp

This block keeps the set of live execution paths of one warp. Each path has a program counter, a stack-depth key and a lane mask. The mask names the lanes whose program counter equals the path's PC. The paths are held in ascending order of the key {SP, PC}. The first slot is therefore always the path to issue next: the one with the deepest call nesting and, among those, the lowest code address. That slot's PC goes to fetch and its mask goes to the execute lanes.

When the issued instruction commits, the pipeline returns one of two results. A uniform result gives the path a new PC and SP and keeps its mask. A divergent result gives a taken target with a taken mask, and a not-taken PC with a not-taken mask. The block removes the committed path and inserts the new path or paths at their sorted positions. Each insertion compares the new key against every stored key in parallel and shifts the lower part of the list down by one. Sorting puts equal PCs next to each other, so reconvergence only needs a check between the first two slots. While those two slots hold the same PC, they are fused into one path whose mask is the OR of both masks.

A small state machine runs the update. It has four states:
- RUN: the top path is offered and a commit is accepted.
- INS_A: the first pending path is inserted.
- INS_B: the second pending path is inserted.
- MERGE: the top two slots are fused, repeating while their PCs match.

The transitions are:
- RUN goes to INS_A on an accepted commit.
- INS_A always goes to INS_B.
- INS_B always goes to MERGE.
- MERGE stays in MERGE while the top two PCs match, and otherwise returns to RUN.
- A load of a fresh warp sends any state to RUN.

Top module: `simt_path_list`

## Requirements
- R1: After reset the list is empty: top_valid is 0, path_count is 0 and overflow is 0.
- R2: A pulse on init_valid clears the list and the overflow flag in any state and enters RUN. If init_mask is nonzero, it stores one path (init_pc, init_sp, init_mask), which is offered on the next cycle with path_count 1. A zero mask leaves the list empty.
- R3: A uniform commit (cmt_diverge 0) removes the top path and re-inserts it with PC cmt_pc, SP cmt_sp and its old mask, at its sorted position.
- R4: A divergent commit (cmt_diverge 1) removes the top path and inserts two paths. The taken path is (cmt_pc, cmt_sp, cmt_tk_mask) and is inserted first. The not-taken path is (cmt_nt_pc, cmt_sp, cmt_nt_mask). A path with an all-zero mask is not inserted, so two zero masks simply retire the path.
- R5: Slots are ordered by ascending SP and, for equal SP, by ascending PC. The top slot is the minimum. A path whose key equals a stored key is placed after it.
- R6: In MERGE, while the first two slots hold the same PC, they fuse at one pair per cycle. The result keeps the first slot's PC and SP and takes the OR of both masks.
- R7: path_count equals the number of stored paths, and top_valid is 0 whenever it is 0.
- R8: cmt_valid is ignored unless top_valid is 1. A commit while busy or empty leaves the list unchanged.
- R9: Inserting a path with a nonzero mask into a full list (DEPTH paths) drops that path and sets overflow. Overflow stays set until reset or init_valid.
- R10: After an accepted commit, top_valid is 0 for exactly three cycles plus one cycle per fusion. After that the new top is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Load a fresh warp, clearing the list |
| init_pc | input | PC_W | PC of the initial path |
| init_sp | input | SP_W | SP key of the initial path |
| init_mask | input | LANES | Lane mask of the initial path |
| cmt_valid | input | 1 | Commit result for the offered path |
| cmt_diverge | input | 1 | 1: divergent branch, 0: uniform update |
| cmt_pc | input | PC_W | New PC (uniform) or taken target (divergent) |
| cmt_sp | input | SP_W | SP key of the resulting path(s) |
| cmt_nt_pc | input | PC_W | Not-taken PC (divergent only) |
| cmt_tk_mask | input | LANES | Taken lane mask (divergent only) |
| cmt_nt_mask | input | LANES | Not-taken lane mask (divergent only) |
| top_valid | output | 1 | A path is offered for issue |
| top_pc | output | PC_W | PC of the offered path |
| top_sp | output | SP_W | SP key of the offered path |
| top_mask | output | LANES | Execution mask of the offered path |
| path_count | output | $clog2(DEPTH+1) | Number of stored paths |
| overflow | output | 1 | Sticky flag for a dropped insertion into a full list |

## Verification
The bench goes after the following corner cases:
- Equal keys. A new path whose key equals a stored key must land behind it. A design that inserts ahead of equal keys reorders paths and offers the wrong mask first.
- Reconvergence. After a branch, both halves must meet again at one PC. A design that skips fusion, or fuses only once, leaves two top slots with the same PC and a split mask.
- SP priority. A path with a smaller SP must win over one with a lower PC. A design that sorts on PC alone issues the shallower path first.
- Commits that must be ignored. Commits arriving while the list is busy or empty must have no effect. A design that accepts them corrupts the list, which shows up as a wrong path_count.
- Full list. Deliberate misuse fills the list. A design that wraps or overwrites when full either loses a stored path or fails to raise the sticky overflow flag.

// File: rtl/simt_path_pkg.sv
package simt_path_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_INS_A,
        ST_INS_B,
        ST_MERGE
    } path_state_e;

    typedef enum logic [2:0] {
        SEL_KEEP,
        SEL_NEXT,
        SEL_PREV,
        SEL_NEW,
        SEL_FUSE,
        SEL_CLEAR
    } slot_sel_e;

endpackage

// File: rtl/path_fsm.sv
module path_fsm
    import simt_path_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_warp,
    input  logic        take_commit,
    input  logic        fuse_hit,
    output path_state_e state,
    output logic        in_run,
    output logic        in_insert,
    output logic        in_merge
);

    path_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (load_warp) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:   if (take_commit) state_nx = ST_INS_A;
                ST_INS_A: state_nx = ST_INS_B;
                ST_INS_B: state_nx = ST_MERGE;
                ST_MERGE: if (!fuse_hit) state_nx = ST_RUN;
                default:  state_nx = ST_RUN;
            endcase
        end
    end

    always_comb begin
        in_run    = (state == ST_RUN);
        in_insert = (state == ST_INS_A) || (state == ST_INS_B);
        in_merge  = (state == ST_MERGE);
    end

endmodule

// File: rtl/path_slot.sv
module path_slot
    import simt_path_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int SP_W  = 8,
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slot_sel_e        sel,
    input  logic             nxt_v,
    input  logic [PC_W-1:0]  nxt_pc,
    input  logic [SP_W-1:0]  nxt_sp,
    input  logic [LANES-1:0] nxt_mask,
    input  logic             prv_v,
    input  logic [PC_W-1:0]  prv_pc,
    input  logic [SP_W-1:0]  prv_sp,
    input  logic [LANES-1:0] prv_mask,
    input  logic [PC_W-1:0]  new_pc,
    input  logic [SP_W-1:0]  new_sp,
    input  logic [LANES-1:0] new_mask,
    output logic             q_v,
    output logic [PC_W-1:0]  q_pc,
    output logic [SP_W-1:0]  q_sp,
    output logic [LANES-1:0] q_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_v    <= 1'b0;
            q_pc   <= '0;
            q_sp   <= '0;
            q_mask <= '0;
        end else begin
            unique case (sel)
                SEL_KEEP: ;
                SEL_NEXT: begin
                    q_v <= nxt_v; q_pc <= nxt_pc; q_sp <= nxt_sp; q_mask <= nxt_mask;
                end
                SEL_PREV: begin
                    q_v <= prv_v; q_pc <= prv_pc; q_sp <= prv_sp; q_mask <= prv_mask;
                end
                SEL_NEW: begin
                    q_v <= 1'b1; q_pc <= new_pc; q_sp <= new_sp; q_mask <= new_mask;
                end
                SEL_FUSE:  q_mask <= q_mask | nxt_mask;
                SEL_CLEAR: begin
                    q_v <= 1'b0; q_pc <= '0; q_sp <= '0; q_mask <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/simt_path_list.sv
module simt_path_list
    import simt_path_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = LANES,
    parameter int PC_W  = 16,
    parameter int SP_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int KEY_W = SP_W + PC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_valid,
    input  logic [PC_W-1:0]  init_pc,
    input  logic [SP_W-1:0]  init_sp,
    input  logic [LANES-1:0] init_mask,
    input  logic             cmt_valid,
    input  logic             cmt_diverge,
    input  logic [PC_W-1:0]  cmt_pc,
    input  logic [SP_W-1:0]  cmt_sp,
    input  logic [PC_W-1:0]  cmt_nt_pc,
    input  logic [LANES-1:0] cmt_tk_mask,
    input  logic [LANES-1:0] cmt_nt_mask,
    output logic             top_valid,
    output logic [PC_W-1:0]  top_pc,
    output logic [SP_W-1:0]  top_sp,
    output logic [LANES-1:0] top_mask,
    output logic [CNT_W-1:0] path_count,
    output logic             overflow
);

    logic [DEPTH-1:0] s_v;
    logic [PC_W-1:0]  s_pc   [DEPTH];
    logic [SP_W-1:0]  s_sp   [DEPTH];
    logic [LANES-1:0] s_mask [DEPTH];

    path_state_e state;
    logic        in_run, in_insert, in_merge;
    logic        take_commit, fuse_hit;

    // pending paths captured at commit
    logic [PC_W-1:0]  pa_pc, pb_pc;
    logic [SP_W-1:0]  pa_sp, pb_sp;
    logic [LANES-1:0] pa_mask, pb_mask;

    // candidate for the current insertion step
    logic [PC_W-1:0]  cd_pc;
    logic [SP_W-1:0]  cd_sp;
    logic [LANES-1:0] cd_mask;
    logic             list_full, do_insert, ovf_set;
    logic [DEPTH-1:0] key_le;
    logic [CNT_W-1:0] ins_pos;
    logic [CNT_W-1:0] cnt;

    assign take_commit = in_run && cmt_valid && s_v[0] && !init_valid;
    assign fuse_hit    = s_v[0] && s_v[1] && (s_pc[0] == s_pc[1]);

    path_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_warp   (init_valid),
        .take_commit (take_commit),
        .fuse_hit    (fuse_hit),
        .state       (state),
        .in_run      (in_run),
        .in_insert   (in_insert),
        .in_merge    (in_merge)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_pc <= '0; pa_sp <= '0; pa_mask <= '0;
            pb_pc <= '0; pb_sp <= '0; pb_mask <= '0;
        end else if (take_commit) begin
            pa_pc   <= cmt_pc;
            pa_sp   <= cmt_sp;
            pa_mask <= cmt_diverge ? cmt_tk_mask : s_mask[0];
            pb_pc   <= cmt_nt_pc;
            pb_sp   <= cmt_sp;
            pb_mask <= cmt_diverge ? cmt_nt_mask : '0;
        end
    end

    always_comb begin
        if (state == ST_INS_B) begin
            cd_pc = pb_pc; cd_sp = pb_sp; cd_mask = pb_mask;
        end else begin
            cd_pc = pa_pc; cd_sp = pa_sp; cd_mask = pa_mask;
        end
    end

    // count of stored paths; valid slots always form a prefix
    always_comb begin
        cnt = '0;
        for (int i = 0; i < DEPTH; i++) cnt = cnt + CNT_W'(s_v[i]);
    end

    assign list_full = (cnt == CNT_W'(DEPTH));
    assign do_insert = in_insert && !init_valid && (cd_mask != '0) && !list_full;
    assign ovf_set   = in_insert && !init_valid && (cd_mask != '0) && list_full;

    // parallel key comparison: slots with key <= candidate stay above it
    always_comb begin
        ins_pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            key_le[i] = s_v[i] &&
                        (KEY_W'({s_sp[i], s_pc[i]}) <= KEY_W'({cd_sp, cd_pc}));
            ins_pos = ins_pos + CNT_W'(key_le[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          overflow <= 1'b0;
        else if (init_valid) overflow <= 1'b0;
        else if (ovf_set)    overflow <= 1'b1;
    end

    logic [PC_W-1:0]  nw_pc;
    logic [SP_W-1:0]  nw_sp;
    logic [LANES-1:0] nw_mask;
    assign nw_pc   = init_valid ? init_pc   : cd_pc;
    assign nw_sp   = init_valid ? init_sp   : cd_sp;
    assign nw_mask = init_valid ? init_mask : cd_mask;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_sel_e        sel;
        logic             nv, pv;
        logic [PC_W-1:0]  npc, ppc;
        logic [SP_W-1:0]  nsp, psp;
        logic [LANES-1:0] nmk, pmk;

        if (g == DEPTH - 1) begin : g_last
            assign nv = 1'b0; assign npc = '0; assign nsp = '0; assign nmk = '0;
        end else begin : g_mid
            assign nv = s_v[g+1]; assign npc = s_pc[g+1];
            assign nsp = s_sp[g+1]; assign nmk = s_mask[g+1];
        end

        if (g == 0) begin : g_first
            assign pv = 1'b0; assign ppc = '0; assign psp = '0; assign pmk = '0;
        end else begin : g_rest
            assign pv = s_v[g-1]; assign ppc = s_pc[g-1];
            assign psp = s_sp[g-1]; assign pmk = s_mask[g-1];
        end

        always_comb begin
            if (init_valid) begin
                sel = (g == 0 && init_mask != '0) ? SEL_NEW : SEL_CLEAR;
            end else if (take_commit) begin
                sel = SEL_NEXT;
            end else if (do_insert) begin
                if (CNT_W'(g) < ins_pos)       sel = SEL_KEEP;
                else if (CNT_W'(g) == ins_pos) sel = SEL_NEW;
                else                           sel = SEL_PREV;
            end else if (in_merge && fuse_hit) begin
                sel = (g == 0) ? SEL_FUSE : SEL_NEXT;
            end else begin
                sel = SEL_KEEP;
            end
        end

        path_slot #(.PC_W(PC_W), .SP_W(SP_W), .LANES(LANES)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .nxt_v    (nv),
            .nxt_pc   (npc),
            .nxt_sp   (nsp),
            .nxt_mask (nmk),
            .prv_v    (pv),
            .prv_pc   (ppc),
            .prv_sp   (psp),
            .prv_mask (pmk),
            .new_pc   (nw_pc),
            .new_sp   (nw_sp),
            .new_mask (nw_mask),
            .q_v      (s_v[g]),
            .q_pc     (s_pc[g]),
            .q_sp     (s_sp[g]),
            .q_mask   (s_mask[g])
        );
    end

    assign top_valid  = in_run && s_v[0];
    assign top_pc     = s_pc[0];
    assign top_sp     = s_sp[0];
    assign top_mask   = s_mask[0];
    assign path_count = cnt;

endmodule

// File: rtl/simt_path_list_chk.sv
module simt_path_list_chk #(
    parameter int LANES = 8,
    parameter int DEPTH = LANES,
    parameter int PC_W  = 16,
    parameter int SP_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_valid,
    input logic [PC_W-1:0]  init_pc,
    input logic [LANES-1:0] init_mask,
    input logic             cmt_valid,
    input logic             top_valid,
    input logic [PC_W-1:0]  top_pc,
    input logic [LANES-1:0] top_mask,
    input logic [CNT_W-1:0] path_count,
    input logic             overflow
);

    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid && init_mask != '0 |=> top_valid && top_pc == $past(init_pc) && path_count == 1) // R2
        else $error("init load not offered");

    AST_TOP_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> top_mask != '0) // R4
        else $error("offered path with empty mask");

    AST_EMPTY_NO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        path_count == 0 |-> !top_valid) // R7
        else $error("offer from empty list");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid && !cmt_valid && !init_valid |=> top_valid && $stable(top_pc) && $stable(top_mask)) // R8
        else $error("top moved without commit");

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !init_valid |=> overflow) // R9
        else $error("overflow cleared");

    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid && cmt_valid && !init_valid |=> !top_valid) // R10
        else $error("no busy after commit");

endmodule

bind simt_path_list simt_path_list_chk #(
    .LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .SP_W(SP_W)
) i_chk (.*);

// File: tb/test_simt_path_list.sv
module test_simt_path_list;

    localparam int LANES = 8;
    localparam int DEPTH = 8;
    localparam int PC_W  = 16;
    localparam int SP_W  = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_valid = 1'b0;
    logic [PC_W-1:0]  init_pc = '0;
    logic [SP_W-1:0]  init_sp = '0;
    logic [LANES-1:0] init_mask = '0;
    logic             cmt_valid = 1'b0;
    logic             cmt_diverge = 1'b0;
    logic [PC_W-1:0]  cmt_pc = '0;
    logic [SP_W-1:0]  cmt_sp = '0;
    logic [PC_W-1:0]  cmt_nt_pc = '0;
    logic [LANES-1:0] cmt_tk_mask = '0;
    logic [LANES-1:0] cmt_nt_mask = '0;
    logic             top_valid;
    logic [PC_W-1:0]  top_pc;
    logic [SP_W-1:0]  top_sp;
    logic [LANES-1:0] top_mask;
    logic [CNT_W-1:0] path_count;
    logic             overflow;

    always #4 clk = ~clk;

    simt_path_list #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .SP_W(SP_W)) i_simt_path_list (
        .clk(clk), .rst_n(rst_n),
        .init_valid(init_valid), .init_pc(init_pc), .init_sp(init_sp), .init_mask(init_mask),
        .cmt_valid(cmt_valid), .cmt_diverge(cmt_diverge), .cmt_pc(cmt_pc), .cmt_sp(cmt_sp),
        .cmt_nt_pc(cmt_nt_pc), .cmt_tk_mask(cmt_tk_mask), .cmt_nt_mask(cmt_nt_mask),
        .top_valid(top_valid), .top_pc(top_pc), .top_sp(top_sp), .top_mask(top_mask),
        .path_count(path_count), .overflow(overflow)
    );

    typedef struct {
        int pc;
        int sp;
        int mask;
    } path_t;

    path_t m_q[$];
    path_t m_a, m_b;
    int    m_ph = 0;
    bit    m_ovf = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 0;

    task automatic chk(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic bit key_le(path_t x, path_t y);
        if (x.sp != y.sp) return x.sp < y.sp;
        return x.pc <= y.pc;
    endfunction

    task automatic m_insert(path_t p);
        int pos = 0;
        if (p.mask == 0) return;
        if (m_q.size() >= DEPTH) begin
            m_ovf = 1;
            return;
        end
        while (pos < m_q.size() && key_le(m_q[pos], p)) pos++;
        m_q.insert(pos, p);
    endtask

    // reference: state after the coming clock edge, from current inputs
    task automatic m_step();
        if (init_valid) begin
            m_q.delete();
            if (init_mask != 0) m_q.push_back('{int'(init_pc), int'(init_sp), int'(init_mask)});
            m_ovf = 0;
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (cmt_valid && m_q.size() > 0) begin
                    path_t t = m_q.pop_front();
                    m_a = '{int'(cmt_pc), int'(cmt_sp), cmt_diverge ? int'(cmt_tk_mask) : t.mask};
                    m_b = '{int'(cmt_nt_pc), int'(cmt_sp), cmt_diverge ? int'(cmt_nt_mask) : 0};
                    m_ph = 1;
                end
                1: begin m_insert(m_a); m_ph = 2; end
                2: begin m_insert(m_b); m_ph = 3; end
                default: begin
                    if (m_q.size() >= 2 && m_q[0].pc == m_q[1].pc) begin
                        m_q[0].mask = m_q[0].mask | m_q[1].mask;
                        m_q.delete(1);
                    end else begin
                        m_ph = 0;
                    end
                end
            endcase
        end
    endtask

    task automatic compare();
        bit ev = (m_ph == 0) && (m_q.size() > 0);
        chk("R10 top_valid", int'(top_valid), int'(ev));
        chk("R7 path_count", int'(path_count), m_q.size());
        chk("R9 overflow", int'(overflow), int'(m_ovf));
        if (ev) begin
            chk("R5 top_pc", int'(top_pc), m_q[0].pc);
            chk("R5 top_sp", int'(top_sp), m_q[0].sp);
            chk("R6 top_mask", int'(top_mask), m_q[0].mask);
        end
    endtask

    task automatic tick();
        m_step();
        @(posedge clk);
        @(negedge clk);
        init_valid = 1'b0;
        cmt_valid  = 1'b0;
        compare();
    endtask

    task automatic wait_run();
        for (int n = 0; n < 40; n++) begin
            if (m_ph == 0) break;
            tick();
        end
    endtask

    task automatic load(int pc, int sp, int mask);
        init_pc = PC_W'(pc); init_sp = SP_W'(sp); init_mask = LANES'(mask);
        init_valid = 1'b1;
        tick();
    endtask

    task automatic commit(bit dv, int pc, int sp, int ntpc, int tk, int nt);
        cmt_diverge = dv; cmt_pc = PC_W'(pc); cmt_sp = SP_W'(sp);
        cmt_nt_pc = PC_W'(ntpc); cmt_tk_mask = LANES'(tk); cmt_nt_mask = LANES'(nt);
        cmt_valid = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 top_valid", int'(top_valid), 0);
        chk("R1 path_count", int'(path_count), 0);
        chk("R1 overflow", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2: initial load
        load(16'h10, 4, 8'hFF);
        chk("R2 top_pc", int'(top_pc), 16'h10);
        chk("R2 top_mask", int'(top_mask), 8'hFF);
        chk("R2 path_count", int'(path_count), 1);

        // R3: uniform update keeps the mask
        commit(0, 16'h11, 4, 0, 0, 0);
        chk("R10 busy after commit", int'(top_valid), 0);
        wait_run();
        chk("R3 top_pc", int'(top_pc), 16'h11);
        chk("R3 top_mask", int'(top_mask), 8'hFF);

        // R4, R5: divergent split, lower PC first
        commit(1, 16'h20, 4, 16'h12, 8'h0F, 8'hF0);
        wait_run();
        chk("R4 path_count", int'(path_count), 2);
        chk("R4 top_pc", int'(top_pc), 16'h12);
        chk("R4 top_mask", int'(top_mask), 8'hF0);

        // R6: reconvergence at 0x20
        commit(0, 16'h20, 4, 0, 0, 0);
        wait_run();
        chk("R6 fused mask", int'(top_mask), 8'hFF);
        chk("R6 path_count", int'(path_count), 1);

        // R5: smaller SP wins over lower PC
        commit(1, 16'h30, 2, 16'h24, 8'h01, 8'hFE);
        wait_run();
        commit(0, 16'h05, 6, 0, 0, 0);
        wait_run();
        chk("R5 SP priority pc", int'(top_pc), 16'h30);
        chk("R5 SP priority sp", int'(top_sp), 2);

        // R5: equal key lands behind the stored one
        load(16'h40, 1, 8'h0F);
        commit(1, 16'h50, 1, 16'h50, 8'h03, 8'h0C);
        wait_run();
        chk("R5 equal key fused", int'(top_mask), 8'h0F);

        // R8: commit while busy and while empty is ignored
        commit(1, 16'h60, 1, 16'h61, 8'h01, 8'h02);
        commit(1, 16'h70, 0, 16'h71, 8'hFF, 8'hFF);
        wait_run();
        chk("R8 busy commit ignored", int'(path_count), 2);
        commit(1, 16'h60, 1, 16'h61, 0, 0);
        wait_run();
        commit(1, 16'h60, 1, 16'h61, 0, 0);
        wait_run();
        chk("R4 retire to empty", int'(path_count), 0);
        commit(0, 16'h99, 0, 0, 0, 0);
        chk("R8 empty commit ignored", int'(path_count), 0);
        load(16'h1, 0, 0);
        chk("R2 zero mask load", int'(path_count), 0);

        // R9: overflow through misuse
        load(16'h0, 0, 8'hFF);
        for (int k = 0; k < DEPTH; k++) begin
            wait_run();
            commit(1, 16'h100 + 2 * k, 0, 16'h101 + 2 * k, 8'h01, 8'h01);
        end
        wait_run();
        chk("R9 overflow set", int'(overflow), 1);
        chk("R9 list stays full", int'(path_count), DEPTH);
        load(16'h5, 0, 8'h0F);
        chk("R9 overflow cleared", int'(overflow), 0);

        // mixed traffic against the model
        for (int k = 0; k < 60; k++) begin
            int r;
            wait_run();
            if (m_q.size() == 0) load(16'h40, 1, 8'hFF);
            r = int'($urandom);
            if (r[20]) commit(0, 16'h40 + 4 * ((r >> 8) % 5), (r >> 16) % 3, 0, 0, 0);
            else commit(1, 16'h40 + 4 * ((r >> 8) % 5), (r >> 16) % 3,
                        16'h40 + 4 * ((r >> 12) % 5),
                        m_q[0].mask & (r & 8'hFF), m_q[0].mask & ~(r & 8'hFF));
        end
        wait_run();

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule